// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

This block keeps a small table of VLAN membership entries. Each entry holds a 12-bit VLAN ID, a per-port member mask and a valid bit. Software does not write the table directly. It writes a data word carrying a member mask, then a command word carrying an operation code, a VLAN ID, a port number and a launch bit. The engine then runs that one operation against the whole table and reports completion through the same command word.

Four table operations exist. A flush empties the table. A load stores one entry. A purge deletes the entry for one VLAN ID. A port removal strips one port from every entry. Every operation except the no-op sweeps the table one entry per clock. While it runs, the active bit of the command word reads back as 1, and any command written in that time is dropped. A separate combinational read port takes a VLAN ID and returns the stored member mask and a hit flag, for use by egress logic. A 3-bit priority field and a priority-enable bit ride in the command word. They are stored and read back but never change any result.

Top module: `vlan_cmd_engine`

## Requirements
- R1: After reset the status word reads 0 and the lookup port misses for every VLAN ID.
- R2: A command write with bit 3 set while idle launches the operation. On the next cycle the status word reads back active=1 (bit 3) and echoes the operation code (bits 2:0: 0 no-op, 1 flush, 2 load, 3 purge, 4 remove port), the port (bits 11:8), the VLAN ID (bits 27:16), the priority (bits 30:28) and the priority enable (bit 31).
- R3: Operation codes 1 to 4 hold active for N_ENTRIES+1 cycles after the launch edge. Codes 0 and 5 to 7 hold it for exactly 1 cycle.
- R4: A load stores the mask from data-word bits 9:0 under the commanded VLAN ID as a valid entry, whatever data bit 11 holds. After active clears, the lookup reports a hit with that mask.
- R5: A load to a VLAN ID already in the table overwrites that entry and takes no free entry, so it succeeds even when the table is full.
- R6: A load that finds neither a matching entry nor a free one sets the full bit (bit 4) and leaves the table unchanged. The next launched command clears the full bit.
- R7: A purge invalidates only the entry whose VLAN ID matches.
- R8: A flush invalidates every entry.
- R9: A port removal clears that port's bit in every valid entry. An entry whose mask becomes zero is invalidated.
- R10: A command written while active is 1 is ignored. The status fields and the table are as if the write never happened.
- R11: The priority and priority-enable fields have no effect on table contents or lookup results.
- R12: A command write with bit 3 clear while idle updates the stored fields but launches nothing. Active stays 0.
- R13: A lookup miss returns hit=0 and a mask of all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWe | input | 1 | Command word write strobe |
| cmdWord | input | 32 | Command word written by software |
| dataWe | input | 1 | Data word write strobe |
| dataWord | input | 32 | Data word; bits 9:0 member mask |
| statusWord | output | 32 | Command word readback with active and full bits |
| lookupVid | input | 12 | VLAN ID presented to the lookup port |
| lookupMask | output | MASK_W | Member mask of the matching entry, 0 on miss |
| lookupHit | output | 1 | A valid entry matches lookupVid |

## Verification
The bench builds the engine with its defaults: 16 entries and 10-bit member masks. With these values it can fill the whole table in a few hundred cycles. That puts the full-table corner within reach: a load of a new VLAN ID reports full, and a load of an existing ID still succeeds. The 10-bit masks let the port-removal sweep reach an entry whose only member is the removed port, so that entry drops out of the table.

// File: rtl/vce_pkg.sv
`timescale 1ns/1ps
package vce_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_FLUSH    = 3'd1,
    OP_LOAD     = 3'd2,
    OP_PURGE    = 3'd3,
    OP_DROPPORT = 3'd4
  } opE;

  typedef struct packed {
    logic launch;
    logic sweep;
    logic commit;
  } strobeT;

  localparam int VID_W  = 12;
  localparam int PORT_W = 4;
endpackage

// File: rtl/vce_ctrl.sv
`timescale 1ns/1ps
module vce_ctrl
  import vce_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int MASK_W    = 10,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWe,
  input  logic [31:0]       cmdWord,
  input  logic              dataWe,
  input  logic [31:0]       dataWord,
  input  logic              noSlot,
  output strobeT            strb,
  output logic [IDX_W-1:0]  idx,
  output logic [2:0]        op,
  output logic [VID_W-1:0]  cmdVid,
  output logic [PORT_W-1:0] cmdPort,
  output logic [MASK_W-1:0] loadMask,
  output logic [31:0]       statusWord
);
  typedef enum logic [1:0] {ST_IDLE, ST_SWEEP, ST_FINISH} stateE;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

  stateE             state;
  logic [2:0]        opQ;
  logic [PORT_W-1:0] portQ;
  logic [VID_W-1:0]  vidQ;
  logic [2:0]        prioQ;
  logic              prioEnQ;
  logic              activeQ;
  logic              fullQ;
  logic [MASK_W-1:0] dataQ;
  logic [MASK_W-1:0] loadMaskQ;
  logic [IDX_W-1:0]  idxQ;
  logic              sweepOp;

  // codes 1..4 walk the table; the rest finish at once
  always_comb begin
    sweepOp = (cmdWord[2:0] != 3'd0) && (cmdWord[2:0] <= 3'd4);
    strb.launch = cmdWe && !activeQ && cmdWord[3];
    strb.sweep  = (state == ST_SWEEP);
    strb.commit = (state == ST_FINISH);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      opQ       <= '0;
      portQ     <= '0;
      vidQ      <= '0;
      prioQ     <= '0;
      prioEnQ   <= 1'b0;
      activeQ   <= 1'b0;
      fullQ     <= 1'b0;
      dataQ     <= '0;
      loadMaskQ <= '0;
      idxQ      <= '0;
    end else begin
      if (dataWe) dataQ <= dataWord[MASK_W-1:0];
      case (state)
        ST_IDLE: begin
          if (cmdWe) begin
            opQ     <= cmdWord[2:0];
            portQ   <= cmdWord[8 +: PORT_W];
            vidQ    <= cmdWord[16 +: VID_W];
            prioQ   <= cmdWord[30:28];
            prioEnQ <= cmdWord[31];
            if (cmdWord[3]) begin
              activeQ   <= 1'b1;
              fullQ     <= 1'b0;
              loadMaskQ <= dataQ;
              idxQ      <= '0;
              state     <= sweepOp ? ST_SWEEP : ST_FINISH;
            end
          end
        end
        ST_SWEEP: begin
          idxQ <= idxQ + 1'b1;
          if (idxQ == LAST_IDX) state <= ST_FINISH;
        end
        default: begin
          activeQ <= 1'b0;
          if (opQ == OP_LOAD) fullQ <= noSlot;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  assign idx        = idxQ;
  assign op         = opQ;
  assign cmdVid     = vidQ;
  assign cmdPort    = portQ;
  assign loadMask   = loadMaskQ;
  assign statusWord = {prioEnQ, prioQ, vidQ, 4'b0, portQ, 3'b0, fullQ, activeQ, opQ};
endmodule

// File: rtl/vce_table.sv
`timescale 1ns/1ps
module vce_table
  import vce_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int MASK_W    = 10,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [IDX_W-1:0]  idx,
  input  logic [2:0]        op,
  input  logic [VID_W-1:0]  cmdVid,
  input  logic [PORT_W-1:0] cmdPort,
  input  logic [MASK_W-1:0] loadMask,
  input  logic [VID_W-1:0]  lookupVid,
  output logic [MASK_W-1:0] lookupMask,
  output logic              lookupHit,
  output logic              noSlot
);
  logic [N_ENTRIES-1:0] validQ;
  logic [VID_W-1:0]     vidArr  [N_ENTRIES];
  logic [MASK_W-1:0]    maskArr [N_ENTRIES];

  logic             matchFoundQ, freeFoundQ;
  logic [IDX_W-1:0] matchIdxQ, freeIdxQ;

  logic [MASK_W-1:0] portBit;
  logic [MASK_W-1:0] strippedMask;
  logic              entryHit;
  logic [N_ENTRIES-1:0] hitVec;

  always_comb begin
    for (int b = 0; b < MASK_W; b++) portBit[b] = (32'(cmdPort) == b);
    strippedMask = maskArr[idx] & ~portBit;
    entryHit     = validQ[idx] && (vidArr[idx] == cmdVid);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ      <= '0;
      matchFoundQ <= 1'b0;
      freeFoundQ  <= 1'b0;
      matchIdxQ   <= '0;
      freeIdxQ    <= '0;
      for (int i = 0; i < N_ENTRIES; i++) begin
        vidArr[i]  <= '0;
        maskArr[i] <= '0;
      end
    end else begin
      if (strb.launch) begin
        matchFoundQ <= 1'b0;
        freeFoundQ  <= 1'b0;
      end
      if (strb.sweep) begin
        case (op)
          OP_FLUSH: validQ[idx] <= 1'b0;
          OP_PURGE: if (entryHit) validQ[idx] <= 1'b0;
          OP_DROPPORT: begin
            if (validQ[idx]) begin
              maskArr[idx] <= strippedMask;
              if (strippedMask == '0) validQ[idx] <= 1'b0;
            end
          end
          OP_LOAD: begin
            // remember the first matching and the first free slot
            if (entryHit && !matchFoundQ) begin
              matchFoundQ <= 1'b1;
              matchIdxQ   <= idx;
            end
            if (!validQ[idx] && !freeFoundQ) begin
              freeFoundQ <= 1'b1;
              freeIdxQ   <= idx;
            end
          end
          default: ;
        endcase
      end
      if (strb.commit && (op == OP_LOAD)) begin
        if (matchFoundQ) begin
          validQ[matchIdxQ]  <= 1'b1;
          vidArr[matchIdxQ]  <= cmdVid;
          maskArr[matchIdxQ] <= loadMask;
        end else if (freeFoundQ) begin
          validQ[freeIdxQ]  <= 1'b1;
          vidArr[freeIdxQ]  <= cmdVid;
          maskArr[freeIdxQ] <= loadMask;
        end
      end
    end
  end

  assign noSlot = !matchFoundQ && !freeFoundQ;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : gHit
    assign hitVec[g] = validQ[g] && (vidArr[g] == lookupVid);
  end

  // lowest matching index wins
  always_comb begin
    lookupHit  = |hitVec;
    lookupMask = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) lookupMask = maskArr[i];
    end
  end
endmodule

// File: rtl/vlan_cmd_engine.sv
`timescale 1ns/1ps
module vlan_cmd_engine
  import vce_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int MASK_W    = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWe,
  input  logic [31:0]       cmdWord,
  input  logic              dataWe,
  input  logic [31:0]       dataWord,
  output logic [31:0]       statusWord,
  input  logic [11:0]       lookupVid,
  output logic [MASK_W-1:0] lookupMask,
  output logic              lookupHit
);
  localparam int IDX_W = $clog2(N_ENTRIES);

  strobeT            strb;
  logic [IDX_W-1:0]  idx;
  logic [2:0]        op;
  logic [VID_W-1:0]  cmdVid;
  logic [PORT_W-1:0] cmdPort;
  logic [MASK_W-1:0] loadMask;
  logic              noSlot;

  vce_ctrl #(.N_ENTRIES(N_ENTRIES), .MASK_W(MASK_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdWord(cmdWord),
    .dataWe(dataWe), .dataWord(dataWord), .noSlot(noSlot),
    .strb(strb), .idx(idx), .op(op), .cmdVid(cmdVid), .cmdPort(cmdPort),
    .loadMask(loadMask), .statusWord(statusWord)
  );

  vce_table #(.N_ENTRIES(N_ENTRIES), .MASK_W(MASK_W)) table_i (
    .clk(clk), .rstN(rstN), .strb(strb), .idx(idx), .op(op),
    .cmdVid(cmdVid), .cmdPort(cmdPort), .loadMask(loadMask),
    .lookupVid(lookupVid), .lookupMask(lookupMask), .lookupHit(lookupHit),
    .noSlot(noSlot)
  );
endmodule

// File: rtl/vlan_cmd_engine_chk.sv
`timescale 1ns/1ps
module vlan_cmd_engine_chk #(
  parameter int N_ENTRIES = 16,
  parameter int MASK_W    = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdWe,
  input logic [31:0]       cmdWord,
  input logic              dataWe,
  input logic [31:0]       dataWord,
  input logic [31:0]       statusWord,
  input logic [11:0]       lookupVid,
  input logic [MASK_W-1:0] lookupMask,
  input logic              lookupHit
);
  localparam int CW = $clog2(N_ENTRIES + 4) + 1;
  logic [CW-1:0] activeRun;

  always_ff @(posedge clk) begin
    if (!rstN) activeRun <= '0;
    else if (statusWord[3]) activeRun <= activeRun + 1'b1;
    else activeRun <= '0;
  end

  AST_LAUNCH_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    (!statusWord[3] && cmdWe && cmdWord[3]) |=> (statusWord[3] && statusWord[31:16] == $past(cmdWord[31:16]))); // R2

  AST_ACTIVE_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    activeRun <= CW'(N_ENTRIES + 1)); // R3

  AST_FULL_FROM_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[4]) |-> (statusWord[2:0] == 3'd2)); // R6

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[3] && cmdWe) |=> (statusWord[31:8] == $past(statusWord[31:8]))); // R10

  AST_NO_SPURIOUS_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    (!statusWord[3] && !(cmdWe && cmdWord[3])) |=> !statusWord[3]); // R12

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !lookupHit |-> (lookupMask == '0)); // R13
endmodule

bind vlan_cmd_engine vlan_cmd_engine_chk #(.N_ENTRIES(N_ENTRIES), .MASK_W(MASK_W)) chk_i (
  .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdWord(cmdWord), .dataWe(dataWe),
  .dataWord(dataWord), .statusWord(statusWord), .lookupVid(lookupVid),
  .lookupMask(lookupMask), .lookupHit(lookupHit)
);

// File: tb/vlan_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module vlan_cmd_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int MW = 10;

  logic          clk = 1'b0;
  logic          rstN;
  logic          cmdWe;
  logic [31:0]   cmdWord;
  logic          dataWe;
  logic [31:0]   dataWord;
  logic [31:0]   statusWord;
  logic [11:0]   lookupVid;
  logic [MW-1:0] lookupMask;
  logic          lookupHit;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  typedef struct {
    logic [11:0]   vid;
    logic          hit;
    logic [MW-1:0] mask;
    string         tag;
  } expT;

  expT expQ[$];
  bit  monBusy = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlan_cmd_engine #(.N_ENTRIES(N), .MASK_W(MW)) dut_i (
    .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdWord(cmdWord), .dataWe(dataWe),
    .dataWord(dataWord), .statusWord(statusWord), .lookupVid(lookupVid),
    .lookupMask(lookupMask), .lookupHit(lookupHit)
  );

  function automatic logic [31:0] mkCmd(input logic [2:0] op, input logic [11:0] vid,
                                        input logic [3:0] port, input logic [2:0] prio,
                                        input logic pen);
    return {pen, prio, vid, 4'b0, port, 3'b0, 1'b0, 1'b1, op};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issueCmd(input logic [31:0] w);
    @(negedge clk);
    cmdWord = w;
    cmdWe   = 1'b1;
    @(negedge clk);
    cmdWe   = 1'b0;
  endtask

  task automatic setData(input logic [31:0] w);
    @(negedge clk);
    dataWord = w;
    dataWe   = 1'b1;
    @(negedge clk);
    dataWe   = 1'b0;
  endtask

  // counts negedge samples with active high, starting just after the launch edge
  task automatic waitIdle(output int n);
    n = 0;
    while (statusWord[3] && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic runCmd(input logic [31:0] w);
    int n;
    issueCmd(w);
    waitIdle(n);
  endtask

  task automatic expectLookup(input logic [11:0] vid, input logic hit,
                              input logic [MW-1:0] mask, input string tag);
    expT e;
    e.vid = vid; e.hit = hit; e.mask = mask; e.tag = tag;
    expQ.push_back(e);
    wait (expQ.size() == 0 && !monBusy);
  endtask

  // monitor: applies each expected lookup and compares the result
  initial begin
    lookupVid = '0;
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        expT e;
        monBusy = 1;
        e = expQ.pop_front();
        lookupVid = e.vid;
        #1;
        check((lookupHit === e.hit) && (lookupMask === e.mask), e.tag,
              {21'b0, lookupHit, lookupMask}, {21'b0, e.hit, e.mask});
        monBusy = 0;
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChk++;
    nBad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    summary();
  end

  initial begin
    int n;
    logic [31:0] w;
    rstN = 1'b0; cmdWe = 1'b0; cmdWord = '0; dataWe = 1'b0; dataWord = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(statusWord == 32'h0, "R1 status after reset", statusWord, 32'h0);
    expectLookup(12'd0, 1'b0, '0, "R1 lookup miss after reset");

    // R4 load with data valid bit clear; R2 echo; R3 sweep length
    setData(32'h0000_000F);
    w = mkCmd(3'd2, 12'd5, 4'd3, 3'd0, 1'b0);
    issueCmd(w);
    check(statusWord == w, "R2 status echo on launch", statusWord, w);
    waitIdle(n);
    check(n == N + 1, "R3 load active cycles", n, N + 1);
    expectLookup(12'd5, 1'b1, 10'h00F, "R4 load stores mask");
    expectLookup(12'd6, 1'b0, '0, "R13 miss returns zero mask");

    // R5 overwrite with priority set; R11 priority without effect
    setData(32'h0000_0BF0);
    runCmd(mkCmd(3'd2, 12'd5, 4'd0, 3'd7, 1'b1));
    check(statusWord[4] == 1'b0, "R5 overwrite not full", statusWord, 32'h0);
    expectLookup(12'd5, 1'b1, 10'h3F0, "R5 R11 overwrite keeps mask");

    // R3 no-op and unused code
    issueCmd(mkCmd(3'd0, 12'd1, 4'd0, 3'd0, 1'b0));
    waitIdle(n);
    check(n == 1, "R3 no-op active cycles", n, 1);
    issueCmd(mkCmd(3'd6, 12'd1, 4'd0, 3'd0, 1'b0));
    waitIdle(n);
    check(n == 1, "R3 unused code active cycles", n, 1);

    // R12 write with launch bit clear
    w = mkCmd(3'd1, 12'd77, 4'd2, 3'd0, 1'b0) & ~32'h8;
    issueCmd(w);
    repeat (3) @(negedge clk);
    check(statusWord == w, "R12 fields stored without launch", statusWord, w);
    expectLookup(12'd5, 1'b1, 10'h3F0, "R12 no flush ran");

    // R10 command during active is dropped
    setData(32'h0000_0001);
    w = mkCmd(3'd2, 12'd9, 4'd0, 3'd0, 1'b0);
    issueCmd(w);
    issueCmd(mkCmd(3'd3, 12'd5, 4'd1, 3'd2, 1'b1));
    check(statusWord == w, "R10 status unchanged by busy write", statusWord, w);
    waitIdle(n);
    expectLookup(12'd5, 1'b1, 10'h3F0, "R10 dropped purge had no effect");
    expectLookup(12'd9, 1'b1, 10'h001, "R10 running load completed");

    // R7 purge
    runCmd(mkCmd(3'd3, 12'd9, 4'd0, 3'd0, 1'b0));
    expectLookup(12'd9, 1'b0, '0, "R7 purged entry gone");
    expectLookup(12'd5, 1'b1, 10'h3F0, "R7 other entry kept");

    // R9 remove port 2
    setData(32'h0000_0004);
    runCmd(mkCmd(3'd2, 12'd10, 4'd0, 3'd0, 1'b0));
    setData(32'h0000_0006);
    runCmd(mkCmd(3'd2, 12'd11, 4'd0, 3'd0, 1'b0));
    issueCmd(mkCmd(3'd4, 12'd0, 4'd2, 3'd0, 1'b0));
    waitIdle(n);
    check(n == N + 1, "R3 remove-port active cycles", n, N + 1);
    expectLookup(12'd10, 1'b0, '0, "R9 emptied entry invalid");
    expectLookup(12'd11, 1'b1, 10'h002, "R9 port bit cleared");
    expectLookup(12'd5, 1'b1, 10'h3F0, "R9 entry without port unchanged");

    // R6 fill the table (2 valid now), then overflow
    setData(32'h0000_0010);
    for (int v = 100; v < 114; v++) runCmd(mkCmd(3'd2, 12'(v), 4'd0, 3'd0, 1'b0));
    check(statusWord[4] == 1'b0, "R6 last free slot used", statusWord, 32'h0);
    expectLookup(12'd113, 1'b1, 10'h010, "R6 last slot loaded");
    runCmd(mkCmd(3'd2, 12'd200, 4'd0, 3'd0, 1'b0));
    check(statusWord[4] == 1'b1, "R6 full reported", statusWord, 32'h10);
    expectLookup(12'd200, 1'b0, '0, "R6 table unchanged when full");
    setData(32'h0000_0155);
    runCmd(mkCmd(3'd2, 12'd5, 4'd0, 3'd0, 1'b0));
    check(statusWord[4] == 1'b0, "R5 R6 match load on full table", statusWord, 32'h0);
    expectLookup(12'd5, 1'b1, 10'h155, "R5 overwrite on full table");

    // R8 flush
    issueCmd(mkCmd(3'd1, 12'd0, 4'd0, 3'd0, 1'b0));
    waitIdle(n);
    check(n == N + 1, "R3 flush active cycles", n, N + 1);
    expectLookup(12'd5, 1'b0, '0, "R8 flush clears vid 5");
    expectLookup(12'd100, 1'b0, '0, "R8 flush clears vid 100");
    expectLookup(12'd113, 1'b0, '0, "R8 flush clears vid 113");

    // R4 boundary VLAN ID and full mask
    setData(32'h0000_0BFF);
    runCmd(mkCmd(3'd2, 12'hFFF, 4'd0, 3'd0, 1'b0));
    expectLookup(12'hFFF, 1'b1, 10'h3FF, "R4 top VLAN ID full mask");

    repeat (2) @(negedge clk);
    summary();
  end
endmodule